// File: doc/BRIEF.md
# Three-State Phase/Frequency Comparator with Lock Flag

This block compares a reference clock with a divided feedback clock and reports the phase error as two pulse outputs. A rising reference edge raises the pump-up output and a rising feedback edge raises the pump-down output. Once both are high, a programmable number of fast-clock cycles elapses and then both clear together. Both outputs therefore carry a guaranteed nonzero pulse even when the inputs are perfectly aligned, which keeps a following charge pump out of its dead zone. The gap between the two pulse widths equals the edge offset, measured in fast-clock cycles.

Both inputs are asynchronous to the fast sampling clock. Each input passes through its own synchronizer and rising-edge detector, so an output rises on the third fast-clock edge after the input change is first sampled. The exclusive-OR of the two pulses is available as a raw phase-error indicator. A lock flag is built on top of it. The flag is judged once per reference period: if the exclusive-OR high time in each of a run of consecutive windows stays under a programmable threshold, the flag sets; the first window that fails clears it.

Top module: `tristate_phase_det`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `upOut`, `dnOut`, `xorOut` and `lockOut` are all 0.
- R2: When the reference edge comes L fast cycles before the feedback edge, `upOut` rises first and is high for L+D+1 cycles, and `dnOut` is high for D+1 cycles. D is the value on `resetDelay`.
- R3: When the feedback edge comes L cycles before the reference edge, `dnOut` rises first and is high for L+D+1 cycles, and `upOut` is high for D+1 cycles.
- R4: With aligned inputs, both outputs pulse for exactly D+1 cycles, including 1 cycle at D=0 and 8 cycles at D=7.
- R5: Once both outputs are high, they stay high together for exactly D+1 cycles and then fall on the same clock edge. Neither output falls at any other time.
- R6: `xorOut` is high for exactly L cycles per comparison, where L is the edge offset, and is 0 throughout an aligned comparison.
- R7: Only one zero crossing: when the reference runs at twice the feedback frequency, `upOut` is high for more cycles than `dnOut`, and when the feedback runs at twice the reference frequency, the opposite holds.
- R8: Each synchronized reference edge closes a window. A window is good when its `xorOut` high count is less than `lockThresh`. `lockOut` sets at the 16th consecutive good window counted from reset, and changes only right after a reference edge.
- R9: `lockOut` clears at the first reference edge that closes a window with an `xorOut` count of at least `lockThresh`. A count of `lockThresh`-1 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference clock, asynchronous |
| fbIn | input | 1 | Divided feedback clock, asynchronous |
| resetDelay | input | 3 | Extra fast cycles both outputs stay high before clearing (D) |
| lockThresh | input | 8 | Exclusive-OR width, in cycles, at or above which a window fails |
| upOut | output | 1 | Pump-up pulse |
| dnOut | output | 1 | Pump-down pulse |
| xorOut | output | 1 | Exclusive-OR of the two pulses |
| lockOut | output | 1 | Lock flag |

## Verification
The hardest case to reach is a lock flag that is set and then lost on the exact window that crosses the threshold. Reaching it needs sixteen clean reference periods after reset, followed by controlled offsets. The stimulus drives whole reference periods at cycle-exact offsets. It first passes an offset one below the threshold, which must keep the flag, and then an offset equal to the threshold. The flag is read at the end of the violating period, where it must still be set, and again one period later, where it must be clear. Harmonic rejection is reached by running the two inputs at a 2:1 frequency ratio in both directions and comparing the total pulse time on each output.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic clearBoth;
  } pdCtrl_t;

  // datapath -> control status
  typedef struct packed {
    logic refEdge;
    logic fbEdge;
    logic bothHigh;
    logic xorNarrow;
  } pdStat_t;
endpackage

// File: rtl/pd_sync_edge.sv
`timescale 1ns/1ps
module pd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-2:0], din};
  end

  // newest synchronized sample high, previous one low
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pd_datapath.sv
`timescale 1ns/1ps
module pd_datapath
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int XOR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [XOR_W-1:0] lockThresh,
  input  pdCtrl_t          ctrl,
  output logic             upQ,
  output logic             dnQ,
  output logic             xorQ,
  output pdStat_t          stat
);
  localparam int NUM_IN = 2;
  localparam logic [XOR_W-1:0] XOR_MAX = {XOR_W{1'b1}};

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] riseVec;
  logic [XOR_W-1:0]  xorCnt;

  assign rawIn = {fbIn, refIn};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    pd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[gi]),
      .rise (riseVec[gi])
    );
  end

  // two set/reset elements: set by own edge, cleared jointly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= (upQ | riseVec[0]) & ~ctrl.clearBoth;
      dnQ <= (dnQ | riseVec[1]) & ~ctrl.clearBoth;
    end
  end

  assign xorQ = upQ ^ dnQ;

  // exclusive-OR width within the current reference window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        xorCnt <= '0;
    else if (riseVec[0])              xorCnt <= '0;
    else if (xorQ && xorCnt != XOR_MAX) xorCnt <= xorCnt + 1'b1;
  end

  always_comb begin
    stat.refEdge   = riseVec[0];
    stat.fbEdge    = riseVec[1];
    stat.bothHigh  = upQ & dnQ;
    stat.xorNarrow = xorCnt < lockThresh;
  end
endmodule

// File: rtl/pd_control.sv
`timescale 1ns/1ps
module pd_control
  import pd_pkg::*;
#(
  parameter int DELAY_W   = 3,
  parameter int LOCK_RUNS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pdStat_t            stat,
  input  logic [DELAY_W-1:0] resetDelay,
  output pdCtrl_t            ctrl,
  output logic               lockQ
);
  localparam int GOOD_W = $clog2(LOCK_RUNS + 1);
  localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(LOCK_RUNS);

  logic [DELAY_W-1:0] delCnt;
  logic [GOOD_W-1:0]  goodCnt;

  // reset-path delay: counts cycles with both outputs high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    delCnt <= '0;
    else if (!stat.bothHigh)      delCnt <= '0;
    else if (delCnt != resetDelay) delCnt <= delCnt + 1'b1;
  end

  always_comb begin
    ctrl.clearBoth = stat.bothHigh && (delCnt == resetDelay);
  end

  // consecutive good reference windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) goodCnt <= '0;
    else if (stat.refEdge) begin
      if (!stat.xorNarrow)         goodCnt <= '0;
      else if (goodCnt != GOOD_FULL) goodCnt <= goodCnt + 1'b1;
    end
  end

  assign lockQ = (goodCnt == GOOD_FULL);
endmodule

// File: rtl/tristate_phase_det.sv
`timescale 1ns/1ps
module tristate_phase_det
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_W     = 3,
  parameter int XOR_W       = 8,
  parameter int LOCK_RUNS   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refIn,
  input  logic               fbIn,
  input  logic [DELAY_W-1:0] resetDelay,
  input  logic [XOR_W-1:0]   lockThresh,
  output logic               upOut,
  output logic               dnOut,
  output logic               xorOut,
  output logic               lockOut
);
  pdCtrl_t ctrlBus;
  pdStat_t statBus;

  pd_datapath #(.SYNC_STAGES(SYNC_STAGES), .XOR_W(XOR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .fbIn       (fbIn),
    .lockThresh (lockThresh),
    .ctrl       (ctrlBus),
    .upQ        (upOut),
    .dnQ        (dnOut),
    .xorQ       (xorOut),
    .stat       (statBus)
  );

  pd_control #(.DELAY_W(DELAY_W), .LOCK_RUNS(LOCK_RUNS)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (statBus),
    .resetDelay (resetDelay),
    .ctrl       (ctrlBus),
    .lockQ      (lockOut)
  );
endmodule

// File: rtl/pd_checker.sv
`timescale 1ns/1ps
module pd_checker #(
  parameter int DELAY_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               upOut,
  input logic               dnOut,
  input logic               lockOut,
  input logic [DELAY_W-1:0] resetDelay,
  input logic               refEdge
);
  localparam int RUN_W = DELAY_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] bothRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                bothRun <= '0;
    else if (!(upOut && dnOut)) bothRun <= '0;
    else if (bothRun != RUN_MAX) bothRun <= bothRun + 1'b1;
  end

  // R1: outputs idle in the first cycle after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!upOut && !dnOut && !lockOut));

  // R5: overlap lasts no longer than the programmed delay plus one
  a_r5_overlap_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (upOut && dnOut) |-> (bothRun <= RUN_W'(resetDelay)));

  // R5: upOut only falls together with dnOut out of the overlap
  a_r5_joint_release_up: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upOut) |-> (!dnOut && $past(dnOut)));

  // R5: dnOut only falls together with upOut out of the overlap
  a_r5_joint_release_dn: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dnOut) |-> (!upOut && $past(upOut)));

  // R8: lock flag changes only right after a reference edge
  a_r8_lock_on_ref_edge: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockOut) || $fell(lockOut)) |-> $past(refEdge));
endmodule

bind tristate_phase_det pd_checker #(.DELAY_W(DELAY_W)) u_pd_checker (
  .clk        (clk),
  .rstN       (rstN),
  .upOut      (upOut),
  .dnOut      (dnOut),
  .lockOut    (lockOut),
  .resetDelay (resetDelay),
  .refEdge    (statBus.refEdge)
);

// File: tb/test_tristate_phase_det.sv
`timescale 1ns/1ps
module test_tristate_phase_det;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic       fbIn = 1'b0;
  logic [2:0] resetDelay = 3'd0;
  logic [7:0] lockThresh = 8'd3;
  logic       upOut, dnOut, xorOut, lockOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int cntUp, cntDn, cntXor, cntBoth, firstUp, firstDn;

  always #10 clk = ~clk;

  tristate_phase_det i_tristate_phase_det (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .resetDelay(resetDelay), .lockThresh(lockThresh),
    .upOut(upOut), .dnOut(dnOut), .xorOut(xorOut), .lockOut(lockOut)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic resetDut();
    rstN = 1'b0; refIn = 1'b0; fbIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one 40-cycle comparison; reference edge at cycle 10, feedback at 10+lead
  task automatic runPeriod(input int lead);
    int rs, fs;
    rs = 10; fs = 10 + lead;
    cntUp = 0; cntDn = 0; cntXor = 0; cntBoth = 0; firstUp = -1; firstDn = -1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (upOut) begin cntUp++; if (firstUp < 0) firstUp = c; end
      if (dnOut) begin cntDn++; if (firstDn < 0) firstDn = c; end
      if (xorOut) cntXor++;
      if (upOut && dnOut) cntBoth++;
      refIn = (c >= rs) && (c < rs + 20);
      fbIn  = (c >= fs) && (c < fs + 20);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; refIn = 1'b1; fbIn = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R1", "up in reset", upOut, 0);
    checkEq("R1", "dn in reset", dnOut, 0);
    checkEq("R1", "lock in reset", lockOut, 0);
    refIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "outputs after release", {upOut, dnOut, xorOut, lockOut}, 0);
  endtask

  task automatic testAligned(input int d);
    resetDelay = 3'(d);
    resetDut();
    runPeriod(0);
    checkEq("R4", "aligned up width", cntUp, d + 1);
    checkEq("R4", "aligned dn width", cntDn, d + 1);
    checkEq("R6", "aligned xor width", cntXor, 0);
    checkEq("R5", "aligned overlap", cntBoth, d + 1);
  endtask

  task automatic testRefLeads(input int lead, input int d);
    resetDelay = 3'(d);
    resetDut();
    runPeriod(lead);
    checkEq("R2", "up width", cntUp, lead + d + 1);
    checkEq("R2", "dn width", cntDn, d + 1);
    checkEq("R2", "up first", int'(firstUp < firstDn), 1);
    checkEq("R5", "overlap", cntBoth, d + 1);
    checkEq("R6", "xor width", cntXor, lead);
  endtask

  task automatic testFbLeads(input int lead, input int d);
    resetDelay = 3'(d);
    resetDut();
    runPeriod(-lead);
    checkEq("R3", "dn width", cntDn, lead + d + 1);
    checkEq("R3", "up width", cntUp, d + 1);
    checkEq("R3", "dn first", int'(firstDn < firstUp), 1);
    checkEq("R6", "xor width", cntXor, lead);
  endtask

  task automatic testFreq(input bit refFast);
    int upT, dnT;
    resetDelay = 3'd0;
    resetDut();
    upT = 0; dnT = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (upOut) upT++;
      if (dnOut) dnT++;
      refIn = refFast ? ((c % 20) < 10) : ((c % 40) < 20);
      fbIn  = refFast ? ((c % 40) < 20) : ((c % 20) < 10);
    end
    if (refFast) checkEq("R7", "ref faster: up beats dn", int'(upT > dnT), 1);
    else         checkEq("R7", "fb faster: dn beats up", int'(dnT > upT), 1);
  endtask

  task automatic testLock();
    resetDelay = 3'd1;
    lockThresh = 8'd3;
    resetDut();
    for (int p = 0; p < 15; p++) runPeriod(0);
    checkEq("R8", "lock after 15 windows", lockOut, 0);
    runPeriod(0);
    checkEq("R8", "lock after 16 windows", lockOut, 1);
    runPeriod(2);
    runPeriod(0);
    checkEq("R9", "width thresh-1 keeps lock", lockOut, 1);
    runPeriod(3);
    checkEq("R9", "lock before window closes", lockOut, 1);
    runPeriod(0);
    checkEq("R9", "lock dropped on violation", lockOut, 0);
    for (int p = 0; p < 15; p++) runPeriod(0);
    checkEq("R8", "relock needs full run", lockOut, 0);
    runPeriod(0);
    checkEq("R8", "relock after 16", lockOut, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testAligned(0);
    testAligned(7);
    testRefLeads(4, 0);
    testRefLeads(5, 3);
    testFbLeads(3, 0);
    testFbLeads(6, 2);
    testFreq(1'b1);
    testFreq(1'b0);
    testLock();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule